// File: doc/BRIEF.md
# Word-Clock-Framed Four-Lane Serial Word Receiver

This block receives four single-data-rate serial lanes coming from a sensing chip. Every lane has its own data line and its own word-clock line. The system clock samples both lines directly, and one bit arrives on each clock cycle. The word clock runs at one sixteenth of the bit rate, and its rising edge marks the first bit of each 16-bit word. The receiver shifts bits in most-significant first. When the next word-clock rising edge arrives, it hands the completed word to the output together with a one-cycle valid strobe.

Each lane checks its own framing. A lane declares lock only after four word-clock periods in a row that each last exactly sixteen bit cycles. A period that is too short, or too long, clears lock and throws away the word in progress. A lane emits words only while it is locked, so no word is emitted after reset or after a framing fault until framing has been re-qualified.

Each lane runs a three-state controller:
- HUNT: no word boundary is known.
- TRAIN: boundaries are seen and good periods are being counted.
- LOCKED: words are delivered.

The transitions are:
- HUNT goes to TRAIN on any word-clock rise.
- TRAIN goes to LOCKED on the rise that completes the fourth good period in a row.
- TRAIN stays in TRAIN, with the good-period count reset, on a rise that ends a short period.
- LOCKED goes back to TRAIN on a rise that ends a short period.
- TRAIN and LOCKED both fall back to HUNT as soon as a seventeenth bit arrives without a rise (overrun).

Top module: `serial_word_rx`

## Requirements
- R1: While reset is held and right after it, every lane shows valid low, lock low and a word of zero.
- R2: The bit sampled in the same cycle as a word-clock rise becomes bit 15 of the word. Each later bit of that period fills the next lower bit, down to bit 0.
- R3: A word is presented, with its valid strobe, two clock edges after the word-clock rise that closes its period. It never appears without a closing rise.
- R4: Lock rises on the word-clock rise that completes the fourth consecutive period of exactly 16 bit cycles.
- R5: Words are emitted only for periods that start at or after the locking rise. The words of the qualifying periods are discarded.
- R6: A rise that ends a period shorter than 16 cycles clears lock, discards that word, and restarts the count of good periods from that rise.
- R7: When a seventeenth bit cycle passes without a word-clock rise, lock clears at once, and the word in progress is never emitted.
- R8: Lanes are independent: framing faults on one lane do not change the words, strobes or lock of another lane.
- R9: The valid strobe lasts exactly one clock cycle per delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every lane, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data_i | input | LANES | Serial data line for each lane |
| wclk_i | input | LANES | Word clock for each lane; its rise marks a word's first bit |
| word_o | output | LANES*WORD_W | Parallel words; lane n occupies bits n*WORD_W and up |
| word_vld_o | output | LANES | One-cycle strobe for each lane when its word updates |
| lane_lock_o | output | LANES | High while the lane's framing is qualified |

## Verification
The bench drives all four lanes at once with different fault patterns:
- a short 12-cycle period before lock is reached;
- a 20-cycle overrun after lock;
- a 15-cycle period and a 17-cycle period on a single lane.

A scoreboard expects exactly the words of the good periods that begin after lock. A design that counted a period off by one, took the word clock's rise as the last bit instead of the first, or shifted LSB first would send mismatched or extra words. A design that kept lock through a bad period, or failed to discard the word in progress, would send a word the scoreboard never queued. Lock is sampled shortly after every rise, and again inside a long period, so lock that rises one period early or late, or that stays up through an overrun, is reported.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_TRAIN  = 2'd1,
        ST_LOCKED = 2'd2
    } lane_state_e;
endpackage

// File: rtl/wclk_edge.sv
// Input capture and word-clock rising-edge detection for one lane.
module wclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic wclk_i,
    output logic data_o,
    output logic rise_o
);
    logic data_q;
    logic wclk_q;
    logic wclk_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= 1'b0;
            wclk_q  <= 1'b0;
            wclk_qq <= 1'b0;
        end else begin
            data_q  <= data_i;
            wclk_q  <= wclk_i;
            wclk_qq <= wclk_q;
        end
    end

    assign data_o = data_q;
    assign rise_o = wclk_q & ~wclk_qq;

    // R3: a rise is a single-cycle event, so words cannot be closed back to back
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/word_shifter.sv
// Shift register that assembles bits MSB first (oldest bit at the top).
module word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    output logic [WORD_W-1:0] shift_o
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[WORD_W-2:0], bit_i};
    end

    assign shift_o = sr_q;
endmodule

// File: rtl/lane_ctrl.sv
// Framing qualification and word hand-off for one lane.
module lane_ctrl
    import serial_word_rx_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int LOCK_PERIODS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic [WORD_W-1:0] shift_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              lock_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam int RUN_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_PERIODS - 1);

    lane_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [RUN_W-1:0]  run_q, run_d;
    logic              period_ok;
    logic              overrun;

    assign period_ok = (cnt_q == CNT_FULL);
    assign overrun   = !rise_i && (cnt_q == CNT_FULL);

    // bit counter since the last rise
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rise_i)         cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            ST_HUNT: begin
                if (rise_i) begin
                    state_d = ST_TRAIN;
                    run_d   = '0;
                end
            end
            ST_TRAIN: begin
                if (rise_i) begin
                    if (!period_ok) begin
                        run_d = '0;
                    end else if (run_q == RUN_LAST) begin
                        state_d = ST_LOCKED;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + RUN_W'(1);
                    end
                end else if (overrun) begin
                    state_d = ST_HUNT;
                    run_d   = '0;
                end
            end
            ST_LOCKED: begin
                if (rise_i && !period_ok) begin
                    state_d = ST_TRAIN;
                    run_d   = '0;
                end else if (overrun) begin
                    state_d = ST_HUNT;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = ST_HUNT;
                run_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_LOCKED && rise_i && period_ok) begin
                word_o  <= shift_i;
                valid_o <= 1'b1;
            end
        end
    end

    assign lock_o = (state_q == ST_LOCKED);

    // R9: strobe is one cycle wide
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R3: every delivered word was closed by a word-clock rise
    a_r3_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rise_i));
    // R4: lock only rises on a word boundary
    a_r4_lock_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(rise_i));
    // R5: a word is only delivered by a locked lane
    a_r5_valid_locked: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> lock_o);
    // R7: a seventeenth bit without a rise removes lock
    a_r7_overrun_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HUNT && !rise_i && cnt_q == CNT_FULL) |=> !lock_o);
endmodule

// File: rtl/serial_word_rx.sv
// Four-lane word-clock-framed serial receiver.
module serial_word_rx #(
    parameter int LANES        = 4,
    parameter int WORD_W       = 16,
    parameter int LOCK_PERIODS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        ser_data_i,
    input  logic [LANES-1:0]        wclk_i,
    output logic [LANES*WORD_W-1:0] word_o,
    output logic [LANES-1:0]        word_vld_o,
    output logic [LANES-1:0]        lane_lock_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic              bit_w;
        logic              rise_w;
        logic [WORD_W-1:0] shift_w;
        logic [WORD_W-1:0] word_w;

        wclk_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .data_i (ser_data_i[l]),
            .wclk_i (wclk_i[l]),
            .data_o (bit_w),
            .rise_o (rise_w)
        );

        word_shifter #(.WORD_W(WORD_W)) u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_i   (bit_w),
            .shift_o (shift_w)
        );

        lane_ctrl #(.WORD_W(WORD_W), .LOCK_PERIODS(LOCK_PERIODS)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise_w),
            .shift_i (shift_w),
            .word_o  (word_w),
            .valid_o (word_vld_o[l]),
            .lock_o  (lane_lock_o[l])
        );

        assign word_o[l*WORD_W +: WORD_W] = word_w;
    end
endmodule

// File: tb/sim_serial_word_rx.sv
`timescale 1ns/1ps
module sim_serial_word_rx;
    localparam int LANES = 4;
    localparam int W     = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES-1:0]   ser_data_i;
    logic [LANES-1:0]   wclk_i;
    logic [LANES*W-1:0] word_o;
    logic [LANES-1:0]   word_vld_o;
    logic [LANES-1:0]   lane_lock_o;

    logic dat_b [LANES];
    logic wck_b [LANES];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [W-1:0] expq [LANES][$];
    bit           have_prev [LANES];
    int           prev_len  [LANES];
    logic [W-1:0] prev_w    [LANES];
    bit           m_lock    [LANES];
    int           m_run     [LANES];
    bit           vld_prev  [LANES];

    always #4 clk = ~clk;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            ser_data_i[l] = dat_b[l];
            wclk_i[l]     = wck_b[l];
        end
    end

    serial_word_rx u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_data_i  (ser_data_i),
        .wclk_i      (wclk_i),
        .word_o      (word_o),
        .word_vld_o  (word_vld_o),
        .lane_lock_o (lane_lock_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int period_len(input int l, input int idx);
        if (l == 1 && idx == 3)  return 12;
        if (l == 2 && idx == 6)  return 20;
        if (l == 3 && idx == 5)  return 15;
        if (l == 3 && idx == 11) return 17;
        return 16;
    endfunction

    function automatic logic [W-1:0] word_for(input int l, input int idx);
        return 16'hA5C3 ^ W'(l << 12) ^ W'(idx * 16'h1357);
    endfunction

    // driver: one framing period on one lane; updates the lane model at the rise
    task automatic send_period(input int l, input logic [W-1:0] w, input int len);
        if (!have_prev[l]) begin
            m_lock[l] = 0; m_run[l] = 0;
        end else if (prev_len[l] == 16) begin
            if (m_lock[l]) expq[l].push_back(prev_w[l]);
            else begin
                m_run[l]++;
                if (m_run[l] == 4) m_lock[l] = 1;
            end
        end else begin
            m_lock[l] = 0; m_run[l] = 0;
        end
        have_prev[l] = 1; prev_len[l] = len; prev_w[l] = w;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            wck_b[l] = (j < len / 2);
            dat_b[l] = (j < W) ? w[W-1-j] : 1'b0;
            if (j == 2)
                chk(lane_lock_o[l] == m_lock[l], $sformatf("R4 R6 lock lane%0d", l),
                    lane_lock_o[l], m_lock[l]);
            if (len >= 19 && j == len - 1)
                chk(lane_lock_o[l] == 1'b0, $sformatf("R7 overrun lock lane%0d", l),
                    lane_lock_o[l], 0);
        end
    endtask

    task automatic run_lane(input int l);
        for (int i = 0; i < 14; i++) send_period(l, word_for(l, i), period_len(l, i));
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            wck_b[l] = 1'b0;
            dat_b[l] = 1'b0;
        end
        chk(lane_lock_o[l] == 1'b0, $sformatf("R7 idle lock lane%0d", l), lane_lock_o[l], 0);
        chk(expq[l].size() == 0, $sformatf("R5 R8 words missing lane%0d", l), expq[l].size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < LANES; l++) begin
                if (word_vld_o[l]) begin
                    chk(!vld_prev[l], $sformatf("R9 strobe width lane%0d", l), 1, 0);
                    if (expq[l].size() == 0) begin
                        chk(1'b0, $sformatf("R5 R6 unexpected word lane%0d", l),
                            word_o[l*W +: W], 0);
                    end else begin
                        logic [W-1:0] e;
                        e = expq[l].pop_front();
                        chk(word_o[l*W +: W] == e, $sformatf("R2 R3 word lane%0d", l),
                            word_o[l*W +: W], e);
                    end
                end
                vld_prev[l] = word_vld_o[l];
            end
        end
    end

    initial begin
        for (int l = 0; l < LANES; l++) begin
            dat_b[l] = 0; wck_b[l] = 0; have_prev[l] = 0; vld_prev[l] = 0;
            m_lock[l] = 0; m_run[l] = 0; prev_len[l] = 0; prev_w[l] = '0;
        end
        repeat (5) @(negedge clk);
        chk(word_vld_o == '0, "R1 valid", word_vld_o, 0);
        chk(lane_lock_o == '0, "R1 lock", lane_lock_o, 0);
        chk(word_o == '0, "R1 word", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lane_lock_o == '0, "R1 lock after release", lane_lock_o, 0);
        fork
            run_lane(0);
            run_lane(1);
            run_lane(2);
            run_lane(3);
        join
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule